// File: doc/BRIEF.md
# Pause Frame Inserter

The block builds an Ethernet flow-control pause frame and places it into a byte-wide transmit stream whenever software asks for one. Software programs a small word-addressed register set: a mode bit that chooses between the reserved multicast destination and a programmed unicast destination, a 16-bit pause time, and a 48-bit unicast address held in two 32-bit words. Writing anything to the trigger word requests one frame.

Client traffic arrives on a byte stream with valid, start and end markers and a ready back-pressure signal. The block forwards client bytes straight through. A pause request never cuts into a client frame: it waits for the client frame's end, then the client is stalled while the 60-byte pause frame, without FCS, goes out. When insertion begins, the frame fields are copied from the registers, so register writes made while a frame is being sent do not change that frame. Requests that arrive while one is already pending or being sent merge into a single further frame.

Top module: `pause_frame_inserter`

## Requirements
- R1: After reset, all registers read 0, tx_valid_o is 0 and cli_ready_o is 1.
- R2: Register words by address: 0 holds the mode bit in bit 16 (1 multicast, 0 unicast) and the pause time in bits 15:0; 1 holds unicast address bits 31:0; 2 holds unicast address bits 47:32 in its bits 15:0, with bits 31:16 reading 0. Reads return the stored values. Address 3 always reads 0.
- R3: A write to address 3, with any data value, produces one pause frame of exactly 60 bytes on consecutive cycles. tx_sop_o is set on the first byte only and tx_eop_o on the last byte only.
- R4: Pause frame bytes, in transmit order: 0-5 destination; 6-11 src_addr_i, bits 47:40 first; 12-13 are 0x88, 0x08; 14-15 are 0x00, 0x01; 16-17 pause time, high byte first; 18-59 are 0x00.
- R5: With the mode bit 1, the destination bytes are 01 80 C2 00 00 01. With the mode bit 0, they are the 48-bit unicast address, bits 47:40 first.
- R6: With no pause frame pending or being sent, cli_ready_o is 1 and each client byte appears on the tx outputs in the same cycle, with its data and markers unchanged.
- R7: A request made during a client frame is held until that frame's end byte is sent. The pause frame then follows, and no start marker appears on the output inside an open frame.
- R8: cli_ready_o is 0 while a pause frame is being sent. Client bytes held during that time are sent after the pause frame ends.
- R9: Any number of requests made while a pause frame is pending or being sent produce exactly one further pause frame.
- R10: Frame fields are captured when insertion starts. Register writes made during the frame do not change it.
- R11: A pause time of 0 is valid and is sent as two zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| src_addr_i | input | 48 | Station source address placed in the frame |
| cli_valid_i | input | 1 | Client byte valid |
| cli_data_i | input | 8 | Client byte |
| cli_sop_i | input | 1 | Client first byte of frame |
| cli_eop_i | input | 1 | Client last byte of frame |
| cli_ready_o | output | 1 | Client byte accepted when high |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_sop_o | output | 1 | Output first byte of frame |
| tx_eop_o | output | 1 | Output last byte of frame |

## Verification
The bench uses the default parameters: FRAME_LEN of 60 and ADDR_W of 2. At this length all 42 padding bytes and both frame markers can be checked byte by byte. The frame is also long enough for several register writes and repeated triggers to land while a frame is in flight, which exercises the capture and merge behaviour. With a 2-bit address, every register word, including the read-as-zero trigger word, is reachable.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int REG_DW   = 32;
  localparam int OFS_CFG  = 0;
  localparam int OFS_DLO  = 1;
  localparam int OFS_DHI  = 2;
  localparam int OFS_TRIG = 3;
  localparam int HDR_BYTES = 18;

  localparam logic [47:0] MCAST_DST = 48'h0180_C200_0001;
  localparam logic [15:0] ETYPE_FC  = 16'h8808;
  localparam logic [15:0] OPC_PAUSE = 16'h0001;

  typedef struct packed {
    logic        mcast;
    logic [15:0] quanta;
    logic [47:0] ucast_dst;
  } pause_cfg_t;
endpackage

// File: rtl/pfi_regs.sv
module pfi_regs
  import pfi_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output pause_cfg_t        cfg_o,
  output logic              trig_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(OFS_DLO);
  localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(OFS_DHI);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);

  logic        mcast_q;
  logic [15:0] quanta_q;
  logic [31:0] dlo_q;
  logic [15:0] dhi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcast_q  <= 1'b0;
      quanta_q <= '0;
      dlo_q    <= '0;
      dhi_q    <= '0;
    end else if (we_i) begin
      if (addr_i == A_CFG) begin
        mcast_q  <= wdata_i[16];
        quanta_q <= wdata_i[15:0];
      end
      if (addr_i == A_DLO) dlo_q <= wdata_i;
      if (addr_i == A_DHI) dhi_q <= wdata_i[15:0];
    end
  end

  assign trig_o = we_i && (addr_i == A_TRIG);

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CFG)      rdata_o = {15'd0, mcast_q, quanta_q};
    else if (addr_i == A_DLO) rdata_o = dlo_q;
    else if (addr_i == A_DHI) rdata_o = {16'd0, dhi_q};
  end

  assign cfg_o.mcast     = mcast_q;
  assign cfg_o.quanta    = quanta_q;
  assign cfg_o.ucast_dst = {dhi_q, dlo_q};

  // R2: a write to address 0 shows up on the next read of that word
  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_CFG |=> cfg_o.quanta == $past(wdata_i[15:0]));
endmodule

// File: rtl/pfi_frame_gen.sv
module pfi_frame_gen
  import pfi_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  pause_cfg_t  cfg_i,
  input  logic [47:0] src_addr_i,
  output logic        active_o,
  output logic [7:0]  data_o,
  output logic        sop_o,
  output logic        eop_o
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam int HW    = $clog2(HDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_BYTES);

  logic [8*HDR_BYTES-1:0] hdr_q;
  logic [CNT_W-1:0]       idx_q;
  logic                   active_q;
  logic [7:0]             hdr_b [HDR_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      hdr_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      hdr_q    <= {cfg_i.mcast ? MCAST_DST : cfg_i.ucast_dst,
                   src_addr_i, ETYPE_FC, OPC_PAUSE, cfg_i.quanta};
    end else if (active_q) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) hdr_b[i] = hdr_q[8*(HDR_BYTES-1-i) +: 8];
  end

  assign active_o = active_q;
  assign data_o   = (active_q && idx_q < HDR_END) ? hdr_b[idx_q[HW-1:0]] : 8'h00;
  assign sop_o    = active_q && idx_q == '0;
  assign eop_o    = active_q && idx_q == LAST_IDX;

  // R3: a frame ends only after the last byte index
  assert_frame_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(idx_q) == LAST_IDX);
  // R10: captured header does not move mid-frame
  assert_snapshot_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) |-> $stable(hdr_q));
  // R9: no restart while a frame is in flight
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/pfi_arbiter.sv
module pfi_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic cli_valid_i,
  input  logic cli_sop_i,
  input  logic cli_eop_i,
  input  logic gen_active_i,
  output logic start_o,
  output logic cli_ready_o
);
  logic pending_q, busy_q, cli_fire;

  assign start_o     = pending_q && !gen_active_i && !busy_q;
  // hold off a new client frame once a request is waiting at a boundary
  assign cli_ready_o = !gen_active_i && !(pending_q && !busy_q);
  assign cli_fire    = cli_valid_i && cli_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      pending_q <= (pending_q && !start_o) || trig_i;
      if (cli_fire) begin
        if (cli_eop_i)      busy_q <= 1'b0;
        else if (cli_sop_i) busy_q <= 1'b1;
      end
    end
  end

  // R8: client stalled during pause emission
  assert_client_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_active_i |-> !cli_ready_o);
  // R9: a waiting request is never dropped before it starts
  assert_pending_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && !start_o |=> pending_q);
endmodule

// File: rtl/pause_frame_inserter.sv
module pause_frame_inserter
  import pfi_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  parameter int ADDR_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [47:0]       src_addr_i,
  input  logic              cli_valid_i,
  input  logic [7:0]        cli_data_i,
  input  logic              cli_sop_i,
  input  logic              cli_eop_i,
  output logic              cli_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sop_o,
  output logic              tx_eop_o
);
  pause_cfg_t cfg;
  logic       trig, start, gen_active, gen_sop, gen_eop;
  logic [7:0] gen_data;

  pfi_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .cfg_o(cfg), .trig_o(trig)
  );

  pfi_arbiter u_arb (
    .clk_i, .rst_ni, .trig_i(trig), .cli_valid_i, .cli_sop_i, .cli_eop_i,
    .gen_active_i(gen_active), .start_o(start), .cli_ready_o
  );

  pfi_frame_gen #(.FRAME_LEN(FRAME_LEN)) u_gen (
    .clk_i, .rst_ni, .start_i(start), .cfg_i(cfg), .src_addr_i,
    .active_o(gen_active), .data_o(gen_data), .sop_o(gen_sop), .eop_o(gen_eop)
  );

  always_comb begin
    if (gen_active) begin
      tx_valid_o = 1'b1;
      tx_data_o  = gen_data;
      tx_sop_o   = gen_sop;
      tx_eop_o   = gen_eop;
    end else begin
      tx_valid_o = cli_valid_i && cli_ready_o;
      tx_data_o  = cli_data_i;
      tx_sop_o   = tx_valid_o && cli_sop_i;
      tx_eop_o   = tx_valid_o && cli_eop_i;
    end
  end

  // output-side frame tracker for the interleave check
  logic out_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_open_q <= 1'b0;
    else if (tx_valid_o && tx_eop_o) out_open_q <= 1'b0;
    else if (tx_valid_o && tx_sop_o) out_open_q <= 1'b1;
  end

  // R7: no frame starts inside another on the output
  assert_no_interleave_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_sop_o |-> !out_open_q);
  // R6: markers only with valid
  assert_marker_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> !tx_sop_o && !tx_eop_o);
endmodule

// File: tb/tb_pause_frame_inserter.sv
module tb_pause_frame_inserter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] src_addr = 48'h02_11_22_33_44_55;
  logic        cli_valid = 1'b0, cli_sop = 1'b0, cli_eop = 1'b0;
  logic [7:0]  cli_data = '0;
  logic        cli_ready, tx_valid, tx_sop, tx_eop;
  logic [7:0]  tx_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] log_data [2048];
  bit         log_sop  [2048];
  bit         log_eop  [2048];
  int         log_n = 0;

  pause_frame_inserter dut (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .src_addr_i(src_addr),
    .cli_valid_i(cli_valid), .cli_data_i(cli_data), .cli_sop_i(cli_sop),
    .cli_eop_i(cli_eop), .cli_ready_o(cli_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_sop_o(tx_sop), .tx_eop_o(tx_eop)
  );

  always #10 clk = ~clk;

  // monitor: sample 5 ns before each rising edge
  initial forever begin
    @(negedge clk); #5;
    if (tx_valid && log_n < 2048) begin
      log_data[log_n] = tx_data;
      log_sop[log_n]  = tx_sop;
      log_eop[log_n]  = tx_eop;
      log_n++;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic send_client(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      bit acc;
      @(negedge clk);
      cli_valid = 1'b1; cli_data = base + 8'(i);
      cli_sop = (i == 0); cli_eop = (i == n - 1);
      #1 acc = cli_ready;
      @(posedge clk);
      while (!acc) begin
        @(negedge clk); #1 acc = cli_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    cli_valid = 1'b0; cli_sop = 1'b0; cli_eop = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(int i, bit mc, logic [47:0] uc, logic [15:0] q);
    logic [143:0] h;
    h = {mc ? 48'h0180_C200_0001 : uc, src_addr, 16'h8808, 16'h0001, q};
    if (i < 18) return h[8*(17-i) +: 8];
    return 8'h00;
  endfunction

  task automatic chk_pause(int pos, bit mc, logic [47:0] uc, logic [15:0] q, string req);
    int bad = -1;
    bit mk = 1;
    for (int i = 0; i < 60; i++) begin
      if (bad < 0 && log_data[pos+i] !== exp_byte(i, mc, uc, q)) bad = i;
      if (log_sop[pos+i] != (i == 0) || log_eop[pos+i] != (i == 59)) mk = 0;
    end
    chk(pos + 60 <= log_n, req, "pause frame length", log_n - pos, 60);
    chk(bad < 0, req, $sformatf("pause byte %0d", bad),
        bad < 0 ? 0 : log_data[pos+bad], bad < 0 ? 0 : exp_byte(bad, mc, uc, q));
    chk(mk, "R3", "sop/eop placement", mk, 1);
  endtask

  function automatic int count_sop(int from);
    int c = 0;
    for (int i = from; i < log_n; i++) if (log_sop[i]) c++;
    return c;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    chk(cli_ready == 1'b1, "R1", "cli_ready after reset", cli_ready, 1);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R1", $sformatf("reg %0d reset", a), d, 0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'hFFFE_ABCD);
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'h1234_5678);
    rd(2'd0, d); chk(d == 32'h0000_ABCD, "R2", "cfg read", d, 32'h0000_ABCD);
    rd(2'd1, d); chk(d == 32'hDEAD_BEEF, "R2", "addr low read", d, 32'hDEAD_BEEF);
    rd(2'd2, d); chk(d == 32'h0000_5678, "R2", "addr high read", d, 32'h0000_5678);
    rd(2'd3, d); chk(d == 32'h0, "R2", "trigger reads zero", d, 0);
    chk(log_n == 0, "R2", "no frame from plain writes", log_n, 0);
  endtask

  task automatic t_multicast;
    int pos;
    wr(2'd0, 32'h0001_1234);
    pos = log_n;
    wr(2'd3, 32'h0000_0000);
    repeat (80) @(negedge clk);
    chk(log_n - pos == 60, "R3", "one frame of 60 bytes", log_n - pos, 60);
    chk_pause(pos, 1'b1, 48'h0, 16'h1234, "R5");
    chk_pause(pos, 1'b1, 48'h0, 16'h1234, "R4");
  endtask

  task automatic t_unicast_zero;
    int pos;
    wr(2'd1, 32'h3344_5566);
    wr(2'd2, 32'h0000_A1B2);
    wr(2'd0, 32'h0000_0000);
    pos = log_n;
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (80) @(negedge clk);
    chk_pause(pos, 1'b0, 48'hA1B2_3344_5566, 16'h0000, "R11");
    chk(log_data[pos] == 8'hA1, "R5", "unicast first byte", log_data[pos], 8'hA1);
  endtask

  task automatic t_passthrough;
    int pos = log_n;
    bit ok = 1;
    send_client(5, 8'h10);
    repeat (3) @(negedge clk);
    chk(log_n - pos == 5, "R6", "client byte count", log_n - pos, 5);
    for (int i = 0; i < 5; i++)
      if (log_data[pos+i] != 8'h10 + 8'(i) || log_sop[pos+i] != (i == 0) ||
          log_eop[pos+i] != (i == 4)) ok = 0;
    chk(ok, "R6", "client bytes and markers", ok, 1);
    chk(cli_ready == 1'b1, "R6", "ready idle", cli_ready, 1);
  endtask

  task automatic t_mid_client;
    int pos = log_n;
    bit ok = 1;
    wr(2'd0, 32'h0001_0F0F);
    fork
      send_client(20, 8'h40);
      begin repeat (6) @(negedge clk); wr(2'd3, 32'h5); end
    join
    repeat (90) @(negedge clk);
    for (int i = 0; i < 20; i++)
      if (log_data[pos+i] != 8'h40 + 8'(i)) ok = 0;
    chk(ok && log_eop[pos+19], "R7", "client frame intact before pause", ok, 1);
    chk_pause(pos + 20, 1'b1, 48'h0, 16'h0F0F, "R7");
  endtask

  task automatic t_stall;
    int pos = log_n;
    bit ok = 1;
    bit rdy;
    wr(2'd3, 32'h0);
    repeat (5) @(negedge clk);
    #1 rdy = cli_ready;
    chk(rdy == 1'b0, "R8", "ready low during pause", rdy, 0);
    send_client(4, 8'hA0);
    repeat (10) @(negedge clk);
    chk_pause(pos, 1'b1, 48'h0, 16'h0F0F, "R8");
    for (int i = 0; i < 4; i++) if (log_data[pos+60+i] != 8'hA0 + 8'(i)) ok = 0;
    chk(ok && log_n - pos == 64, "R8", "held client bytes after pause", log_n - pos, 64);
  endtask

  task automatic t_coalesce;
    int pos = log_n;
    wr(2'd0, 32'h0001_0042);
    wr(2'd3, 32'h1);
    repeat (5) @(negedge clk);
    wr(2'd3, 32'h2);
    wr(2'd3, 32'h3);
    wr(2'd3, 32'h4);
    repeat (200) @(negedge clk);
    chk(count_sop(pos) == 2, "R9", "frames from merged triggers", count_sop(pos), 2);
    chk(log_n - pos == 120, "R9", "bytes from merged triggers", log_n - pos, 120);
    chk_pause(pos + 60, 1'b1, 48'h0, 16'h0042, "R9");
  endtask

  task automatic t_snapshot;
    int pos;
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h0000_7777);
    pos = log_n;
    wr(2'd3, 32'h0);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h0001_9999);
    wr(2'd1, 32'hFFFF_FFFF);
    repeat (80) @(negedge clk);
    chk_pause(pos, 1'b0, 48'h0002_0000_0001, 16'h7777, "R10");
    pos = log_n;
    wr(2'd3, 32'h0);
    repeat (80) @(negedge clk);
    chk_pause(pos, 1'b1, 48'h0, 16'h9999, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_multicast();
    t_unicast_zero();
    t_passthrough();
    t_mid_client();
    t_stall();
    t_coalesce();
    t_snapshot();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule